// File: doc/BRIEF.md
# Multi-Queue Read Port with Null Queue

This block is the read side of a four-queue FIFO controller. It holds four small internal queues, each with its own write and read pointers and occupancy tracking, and one output register that can deliver a word on every clock. Switching from one queue to another costs no cycle, because the queue named by a new read address is used on the same edge that samples that address.

A 6-bit read address picks a queue. When address bit 2 is set, the address names the null queue instead. The null queue always reads as empty. Switching to it leaves the last delivered word in the output register and raises the active-low output-valid flag, so the reader can see that no new data is present. The null queue may stay selected for any length of time. It has no effect on the write side, which keeps filling queues while the reader is parked on it.

Top module: `mq_read_port`

## Requirements
- R1: After reset, `rd_valid_n` is 1, `rd_data` is 0, every queue is empty and the null queue is selected.
- R2: A write with `wr_en` stores `wr_data` at the tail of queue `wr_qsel`, and words leave in the order written. `wr_full` is 1 when queue `wr_qsel` holds DEPTH words. A write to a full queue is dropped.
- R3: The read address is decoded as follows. Bit 2 = 1 selects the null queue, whatever the other bits hold. Bit 2 = 0 selects the queue numbered by bits [1:0]. Bits [5:3] are ignored.
- R4: A queue switch takes effect on the edge that samples `rd_addr` with `rd_addr_stb` = 1, and a read in that same cycle is served from the new queue. Without the strobe, the previous selection is kept.
- R5: A read (`rd_en`) from a non-empty real queue puts its oldest word on `rd_data` with `rd_valid_n` = 0 after that edge. Reads on consecutive cycles deliver consecutive words with no gap, including across queue switches.
- R6: A read from an empty real queue changes no pointer, sets `rd_valid_n` to 1 and leaves `rd_data` holding the last word.
- R7: A strobe that selects the null queue sets `rd_valid_n` to 1 after that edge, and `rd_data` keeps the last word. Reads while the null queue is selected fetch nothing, for any number of cycles, and queue contents are preserved.
- R8: In a cycle with neither `rd_en` nor `rd_addr_stb`, `rd_data` and `rd_valid_n` hold their values.
- R9: Writes made while the null queue is selected for reading are stored and can be read later.
- R10: At the empty boundary, a word written into an empty queue in the same cycle as a read of that queue is not delivered by that read. It is delivered by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_qsel | input | 2 | Queue written, and queue reported on `wr_full` |
| wr_data | input | DATA_W | Write data |
| wr_full | output | 1 | Queue `wr_qsel` is full |
| rd_addr | input | 6 | Read address (bit 2 = null queue, bits [1:0] = queue) |
| rd_addr_stb | input | 1 | Load `rd_addr` as the new read selection |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output register |
| rd_valid_n | output | 1 | Active-low output-valid flag |

## Verification
The bench builds the block with its defaults, DATA_W = 16 and DEPTH = 4. The small depth lets a few writes reach the full boundary, so the dropped fifth word can be shown to be absent when the queue is drained. Read addresses carry non-zero values in the ignored upper bits, and one null-queue address has both low bits set. This shows that bit 2 alone decides the null selection, and that a queue holding data under those low bits is not touched.

// File: rtl/mq_pkg.sv
package mq_pkg;

    localparam int NUM_Q    = 4;
    localparam int QSEL_W   = $clog2(NUM_Q);
    localparam int RADDR_W  = 6;
    localparam int NULL_BIT = QSEL_W;

    typedef struct packed {
        logic              is_null;
        logic [QSEL_W-1:0] idx;
    } qsel_t;

    localparam qsel_t QSEL_NULL = '{is_null: 1'b1, idx: '0};

    function automatic qsel_t decode_raddr(input logic [RADDR_W-1:0] a);
        qsel_t s;
        s.is_null = a[NULL_BIT];
        s.idx     = a[QSEL_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/mq_queue_store.sv
module mq_queue_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/mq_rd_select.sv
module mq_rd_select
    import mq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RADDR_W-1:0] addr,
    input  logic               stb,
    output qsel_t              eff,
    output qsel_t              cur
);
    assign eff = stb ? decode_raddr(addr) : cur;

    always_ff @(posedge clk) begin
        if (rst) cur <= QSEL_NULL;
        else     cur <= eff;
    end

    assert_null_decode_R3: assert property (@(posedge clk) disable iff (rst)
        (stb && addr[NULL_BIT]) |=> cur.is_null);
    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(cur));

endmodule

// File: rtl/mq_read_port.sv
module mq_read_port
    import mq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [QSEL_W-1:0]  wr_qsel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               wr_full,
    input  logic [RADDR_W-1:0] rd_addr,
    input  logic               rd_addr_stb,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid_n
);
    qsel_t             eff, cur;
    logic [NUM_Q-1:0]  q_empty, q_full, q_pop;
    logic [DATA_W-1:0] q_head [NUM_Q];
    logic              fetch;

    mq_rd_select u_sel (
        .clk  (clk),
        .rst  (rst),
        .addr (rd_addr),
        .stb  (rd_addr_stb),
        .eff  (eff),
        .cur  (cur)
    );

    assign fetch = rd_en && !eff.is_null && !q_empty[eff.idx];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        assign q_pop[q] = fetch && (eff.idx == QSEL_W'(q));
        mq_queue_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
            .clk       (clk),
            .rst       (rst),
            .push      (wr_en && (wr_qsel == QSEL_W'(q))),
            .push_data (wr_data),
            .pop       (q_pop[q]),
            .head      (q_head[q]),
            .empty     (q_empty[q]),
            .full      (q_full[q])
        );
    end

    assign wr_full = q_full[wr_qsel];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            rd_valid_n <= 1'b1;
        end else if (fetch) begin
            rd_data    <= q_head[eff.idx];
            rd_valid_n <= 1'b0;
        end else if (rd_en || (rd_addr_stb && eff.is_null)) begin
            rd_valid_n <= 1'b1;
        end
    end

    assert_fetch_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !eff.is_null && !q_empty[eff.idx]) |=> !rd_valid_n);
    assert_null_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && eff.is_null) |=> (rd_valid_n && $stable(rd_data)));
    assert_single_pop_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_pop));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !rd_addr_stb) |=> ($stable(rd_data) && $stable(rd_valid_n)));

endmodule

// File: tb/mq_read_port_tb.sv
module mq_read_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_qsel = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full;
    logic [5:0]    rd_addr = '0;
    logic          rd_addr_stb = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mq_read_port #(.DATA_W(DW), .DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_qsel(wr_qsel), .wr_data(wr_data),
        .wr_full(wr_full), .rd_addr(rd_addr), .rd_addr_stb(rd_addr_stb),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid_n(rd_valid_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic out_is(input string req, input logic [DW-1:0] d, input logic vn);
        chk(req, 32'(rd_data), 32'(d));
        chk(req, 32'(rd_valid_n), 32'(vn));
    endtask

    // one clock: inputs applied away from the edge, released after it
    task automatic cyc(input logic stb, input logic [5:0] a, input logic re,
                       input logic we, input logic [1:0] wq, input logic [DW-1:0] wd);
        rd_addr_stb = stb; rd_addr = a; rd_en = re;
        wr_en = we; wr_qsel = wq; wr_data = wd;
        @(posedge clk); #1;
        rd_addr_stb = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] q, input logic [DW-1:0] d);
        cyc(1'b0, 6'd0, 1'b0, 1'b1, q, d);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        out_is("R1", '0, 1'b1);
        wr_qsel = 2'd1; #1;
        chk("R1", 32'(wr_full), 0);
        cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd0, '0); // null selected after reset
        out_is("R1", '0, 1'b1);
    endtask

    task automatic t_stream;
        wr(2'd0, 16'hA000); wr(2'd0, 16'hA001); wr(2'd0, 16'hA002);
        wr(2'd1, 16'hB000); wr(2'd1, 16'hB001);
        cyc(1'b1, 6'b000000, 1'b1, 1'b0, 2'd0, '0);
        out_is("R4", 16'hA000, 1'b0);
        cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd0, '0);
        out_is("R5", 16'hA001, 1'b0);
        cyc(1'b1, 6'b101001, 1'b1, 1'b0, 2'd0, '0); // R3 upper bits ignored
        out_is("R3", 16'hB000, 1'b0);
        cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd0, '0);
        out_is("R5", 16'hB001, 1'b0);
        cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd0, '0);
        out_is("R6", 16'hB001, 1'b1);
    endtask

    task automatic t_null;
        cyc(1'b1, 6'b000000, 1'b1, 1'b0, 2'd0, '0);
        out_is("R5", 16'hA002, 1'b0);
        cyc(1'b1, 6'b000100, 1'b0, 1'b0, 2'd0, '0);
        out_is("R7", 16'hA002, 1'b1);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd0, '0);
            out_is("R7", 16'hA002, 1'b1);
        end
        wr(2'd3, 16'hC000);                          // R9 write while null
        cyc(1'b1, 6'b110111, 1'b1, 1'b0, 2'd0, '0);  // R3 bit 2 dominates
        out_is("R3", 16'hA002, 1'b1);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 6'd0, 1'b0, 1'b0, 2'd0, '0);
            out_is("R8", 16'hA002, 1'b1);
        end
        cyc(1'b1, 6'b000011, 1'b1, 1'b0, 2'd0, '0);
        out_is("R9", 16'hC000, 1'b0);
        cyc(1'b0, 6'd0, 1'b0, 1'b0, 2'd0, '0);
        out_is("R8", 16'hC000, 1'b0);
    endtask

    task automatic t_full;
        for (int i = 0; i < 4; i++) wr(2'd2, DW'(16'hD000 + i));
        wr_qsel = 2'd2; #1;
        chk("R2", 32'(wr_full), 1);
        wr(2'd2, 16'hD004);                          // dropped
        cyc(1'b1, 6'b011010, 1'b1, 1'b0, 2'd2, '0);
        out_is("R2", 16'hD000, 1'b0);
        for (int i = 1; i < 4; i++) begin
            cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd2, '0);
            out_is("R2", DW'(16'hD000 + i), 1'b0);
        end
        cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd2, '0);
        out_is("R2", 16'hD003, 1'b1);
        chk("R2", 32'(wr_full), 0);
    endtask

    task automatic t_boundary;
        cyc(1'b1, 6'b000000, 1'b1, 1'b1, 2'd0, 16'hE000);
        out_is("R10", 16'hD003, 1'b1);
        cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd0, '0);
        out_is("R10", 16'hE000, 1'b0);
        cyc(1'b0, 6'd0, 1'b1, 1'b0, 2'd0, '0);
        out_is("R6", 16'hE000, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stream();
        t_null();
        t_full();
        t_boundary();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule